// File: doc/BRIEF.md
# Persistent Fault Shutdown Latch

This block turns per-rail fault indications into a single shutdown decision for a multi-rail power controller. It ORs the fault flags of all monitored rails and times how long that combined condition holds without a break. The time is counted in pulses of a microsecond strobe. When the combined fault has held for the full window, the block sets a shutdown latch.

While the latch is set, every regulator enable and the switch enable are forced low. The reference enable still follows its request. The latch stays set after the faults go away. It is released only when the main-supply-ok flag drops, which models the input falling below its undervoltage threshold.

Timing is suppressed while soft-start runs, because outputs are still ramping then. The surrounding sequencer supplies the enable requests and the block gates them. The fault comparators themselves are outside this block.

Top module: `fault_guard`

## Requirements
- R1: The timer advances on each `usTick` pulse while the OR of all `railFault` bits is 1. The latch `faultLatched` becomes 1 right after the clock edge that samples the `TIMEOUT_TICKS`-th such consecutive pulse, whichever rails contribute to the OR.
- R2: A single clock cycle with all `railFault` bits at 0 returns the timer to zero. A later fault then needs a full new `TIMEOUT_TICKS` pulses to trip the latch.
- R3: While `faultLatched` is 1, `regEnable` is all zeros and `switchEnable` is 0, while `refEnable` still equals `refReq`.
- R4: While `faultLatched` is 0, `regEnable` equals `regReq`, `switchEnable` equals `switchReq` and `refEnable` equals `refReq`.
- R5: Once set, the latch stays 1 while `supplyOk` is 1, even after every `railFault` bit returns to 0.
- R6: A clock edge that samples `supplyOk` at 0 clears the latch and the timer. No timing happens while `supplyOk` is 0. After `supplyOk` returns to 1, a persistent fault trips the latch again after a full `TIMEOUT_TICKS` pulses.
- R7: While `softStartActive` is 1, the timer is held at zero and the latch cannot set. When soft-start ends, a persistent fault needs a full `TIMEOUT_TICKS` pulses from that point.
- R8: Clock cycles with `usTick` at 0 do not advance the timer. They also do not break a continuous fault.
- R9: After reset (`rstN` low), `faultLatched` is 0 and the timer is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-cycle pulse, once per microsecond |
| railFault | input | NUM_RAILS | Per-rail fault flags, 1 = fault |
| softStartActive | input | 1 | 1 while any rail is soft-starting |
| supplyOk | input | 1 | Main input above undervoltage threshold |
| regReq | input | NUM_RAILS | Regulator enable requests from the sequencer |
| switchReq | input | 1 | Switch block enable request |
| refReq | input | 1 | Reference enable request |
| regEnable | output | NUM_RAILS | Gated regulator enables |
| switchEnable | output | 1 | Gated switch block enable |
| refEnable | output | 1 | Reference enable, never gated by the latch |
| faultLatched | output | 1 | Shutdown latch state |

## Verification
The bench places its expectations on the exact cycle before and after the trip edge. A timer that is off by one pulse therefore fails in either direction. One fault is broken by a single clean cycle and one is carried across a hand-off between rails. A design that holds the count across the gap trips early, and one that times rails separately never trips.

Soft-start is asserted both before a fault and in the middle of a count. A design that only pauses the timer, instead of zeroing it, trips too soon. Sparse tick patterns catch a timer that counts clock cycles. Fault removal followed by a supply drop, with the fault still present, catches a latch that clears on fault removal or a timer that keeps counting through undervoltage.

// File: rtl/fg_pkg.sv
package fg_pkg;

  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic timerClr;   // return timer to zero
    logic timerInc;   // advance timer by one pulse
    logic latchSet;   // trip the shutdown latch
    logic latchClr;   // release the shutdown latch
  } fgStrobe_t;

  // Coarse operating phase, derived each cycle by the control path.
  typedef enum logic [2:0] {
    PH_UNDERVOLT = 3'd0,
    PH_RAMPING   = 3'd1,
    PH_WATCH     = 3'd2,
    PH_TIMING    = 3'd3,
    PH_TRIPPED   = 3'd4
  } fgPhase_t;

endpackage

// File: rtl/fg_datapath.sv
module fg_datapath
  import fg_pkg::*;
#(
  parameter int NUM_RAILS     = 3,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fgStrobe_t            strobe,
  input  logic [NUM_RAILS-1:0] regReq,
  input  logic                 switchReq,
  input  logic                 refReq,
  output logic                 termCount,
  output logic                 latched,
  output logic [NUM_RAILS-1:0] regEnable,
  output logic                 switchEnable,
  output logic                 refEnable
);

  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             latchQ;

  // Consecutive-pulse counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.timerClr) begin
      tickCnt <= '0;
    end else if (strobe.timerInc) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  assign termCount = (tickCnt == LAST_CNT);

  // Shutdown latch; release has priority over set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (strobe.latchClr) begin
      latchQ <= 1'b0;
    end else if (strobe.latchSet) begin
      latchQ <= 1'b1;
    end
  end

  assign latched = latchQ;

  // Per-rail gating of regulator enables.
  for (genvar gi = 0; gi < NUM_RAILS; gi++) begin : g_gate
    assign regEnable[gi] = regReq[gi] & ~latchQ;
  end

  assign switchEnable = switchReq & ~latchQ;
  assign refEnable    = refReq;

endmodule

// File: rtl/fg_control.sv
module fg_control
  import fg_pkg::*;
#(
  parameter int NUM_RAILS = 3
) (
  input  logic [NUM_RAILS-1:0] railFault,
  input  logic                 usTick,
  input  logic                 softStartActive,
  input  logic                 supplyOk,
  input  logic                 termCount,
  input  logic                 latched,
  output fgStrobe_t            strobe,
  output fgPhase_t             phase
);

  // OR-reduce the rail flags through an explicit chain.
  logic [NUM_RAILS:0] orChain;
  assign orChain[0] = 1'b0;
  for (genvar gi = 0; gi < NUM_RAILS; gi++) begin : g_or
    assign orChain[gi+1] = orChain[gi] | railFault[gi];
  end

  logic anyFault;
  logic faultQual;

  assign anyFault = orChain[NUM_RAILS];

  always_comb begin
    if (!supplyOk) begin
      phase = PH_UNDERVOLT;
    end else if (latched) begin
      phase = PH_TRIPPED;
    end else if (softStartActive) begin
      phase = PH_RAMPING;
    end else if (anyFault) begin
      phase = PH_TIMING;
    end else begin
      phase = PH_WATCH;
    end
  end

  assign faultQual = (phase == PH_TIMING);

  always_comb begin
    strobe          = '0;
    strobe.latchClr = (phase == PH_UNDERVOLT);
    strobe.timerClr = ~faultQual;
    strobe.timerInc = faultQual & usTick & ~termCount;
    strobe.latchSet = faultQual & usTick & termCount;
  end

endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int NUM_RAILS     = 3,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 usTick,
  input  logic [NUM_RAILS-1:0] railFault,
  input  logic                 softStartActive,
  input  logic                 supplyOk,
  input  logic [NUM_RAILS-1:0] regReq,
  input  logic                 switchReq,
  input  logic                 refReq,
  output logic [NUM_RAILS-1:0] regEnable,
  output logic                 switchEnable,
  output logic                 refEnable,
  output logic                 faultLatched
);

  fgStrobe_t strobe;
  fgPhase_t  phase;
  logic      termCount;
  logic      latched;

  fg_control #(.NUM_RAILS(NUM_RAILS)) ctrl_i (
    .railFault       (railFault),
    .usTick          (usTick),
    .softStartActive (softStartActive),
    .supplyOk        (supplyOk),
    .termCount       (termCount),
    .latched         (latched),
    .strobe          (strobe),
    .phase           (phase)
  );

  fg_datapath #(
    .NUM_RAILS     (NUM_RAILS),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .regReq       (regReq),
    .switchReq    (switchReq),
    .refReq       (refReq),
    .termCount    (termCount),
    .latched      (latched),
    .regEnable    (regEnable),
    .switchEnable (switchEnable),
    .refEnable    (refEnable)
  );

  assign faultLatched = latched;

endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int NUM_RAILS     = 3,
  parameter int TIMEOUT_TICKS = 50000
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 usTick,
  input logic [NUM_RAILS-1:0] railFault,
  input logic                 softStartActive,
  input logic                 supplyOk,
  input logic [NUM_RAILS-1:0] regReq,
  input logic                 switchReq,
  input logic [NUM_RAILS-1:0] regEnable,
  input logic                 switchEnable,
  input logic                 faultLatched
);

  localparam int RUN_W = $clog2(TIMEOUT_TICKS + 1) + 1;

  // Independent count of qualifying pulses in the current fault run.
  logic [RUN_W-1:0] runCnt;
  logic             qualRun;

  assign qualRun = (|railFault) & ~softStartActive & supplyOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!qualRun) begin
      runCnt <= '0;
    end else if (usTick && !faultLatched && runCnt < RUN_W'(TIMEOUT_TICKS)) begin
      runCnt <= runCnt + RUN_W'(1);
    end
  end

  AST_TRIP_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> runCnt == RUN_W'(TIMEOUT_TICKS)); // R1

  AST_SHUTDOWN_GATES: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (regEnable == '0) && !switchEnable); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !faultLatched |-> (regEnable == regReq) && (switchEnable == switchReq)); // R4

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched && supplyOk |=> faultLatched); // R5

  AST_UNDERVOLT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !faultLatched); // R6

  AST_RAMP_MASK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> $past(!softStartActive)); // R7

endmodule

bind fault_guard fg_checker #(
  .NUM_RAILS     (NUM_RAILS),
  .TIMEOUT_TICKS (TIMEOUT_TICKS)
) chk_i (
  .clk             (clk),
  .rstN            (rstN),
  .usTick          (usTick),
  .railFault       (railFault),
  .softStartActive (softStartActive),
  .supplyOk        (supplyOk),
  .regReq          (regReq),
  .switchReq       (switchReq),
  .regEnable       (regEnable),
  .switchEnable    (switchEnable),
  .faultLatched    (faultLatched)
);

// File: tb/fault_guard_tb_top.sv
`timescale 1ns/1ps
module fault_guard_tb_top;

  localparam int NR = 3;
  localparam int TO = 20;

  typedef struct {
    int          cyc;
    bit          lat;
    logic [NR-1:0] reg_e;
    bit          sw;
    bit          ref_e;
    string       tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN;
  logic          usTick;
  logic [NR-1:0] railFault;
  logic          softStartActive;
  logic          supplyOk;
  logic [NR-1:0] regReq;
  logic          switchReq;
  logic          refReq;
  logic [NR-1:0] regEnable;
  logic          switchEnable;
  logic          refEnable;
  logic          faultLatched;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fault_guard #(.NUM_RAILS(NR), .TIMEOUT_TICKS(TO)) dut_i (
    .clk             (clk),
    .rstN            (rstN),
    .usTick          (usTick),
    .railFault       (railFault),
    .softStartActive (softStartActive),
    .supplyOk        (supplyOk),
    .regReq          (regReq),
    .switchReq       (switchReq),
    .refReq          (refReq),
    .regEnable       (regEnable),
    .switchEnable    (switchEnable),
    .refEnable       (refEnable),
    .faultLatched    (faultLatched)
  );

  // Driver side: queue what the outputs must show d cycles from now.
  task automatic expectAt(input int d, input bit lat, input string tag);
    expItem_t it;
    it.cyc   = cyc + d;
    it.lat   = lat;
    it.reg_e = lat ? '0 : regReq;
    it.sw    = lat ? 1'b0 : switchReq;
    it.ref_e = refReq;
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic releaseLatch();
    railFault = '0;
    supplyOk  = 1'b0;
    step(1);
    supplyOk  = 1'b1;
    step(2);
  endtask

  // Monitor side: pop and compare at the falling edge.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (it.cyc != cyc) begin
        failures++;
        $display("FAIL %s: item for cycle %0d missed, now %0d", it.tag, it.cyc, cyc);
      end else if (faultLatched !== it.lat || regEnable !== it.reg_e ||
                   switchEnable !== it.sw || refEnable !== it.ref_e) begin
        failures++;
        $display("FAIL %s: cyc %0d actual lat=%b reg=%b sw=%b ref=%b expected lat=%b reg=%b sw=%b ref=%b",
                 it.tag, cyc, faultLatched, regEnable, switchEnable, refEnable,
                 it.lat, it.reg_e, it.sw, it.ref_e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; usTick = 1'b1; railFault = '0; softStartActive = 1'b0;
    supplyOk = 1'b1; regReq = '1; switchReq = 1'b1; refReq = 1'b1;
    step(3);
    rstN = 1'b1;
    expectAt(0, 1'b0, "R9 reset state");
    step(2);

    // R4: requests pass through when not latched
    regReq = 3'b101; switchReq = 1'b0;
    expectAt(0, 1'b0, "R4 pattern a");
    step(1);
    regReq = 3'b010; switchReq = 1'b1;
    expectAt(0, 1'b0, "R4 pattern b");
    step(1);
    regReq = '1;
    step(1);

    // R1 + R3: single rail, trip exactly on the TO-th pulse
    railFault = 3'b001;
    expectAt(TO-1, 1'b0, "R1 one before trip");
    expectAt(TO,   1'b1, "R1 R3 trip and gating");
    step(TO);

    // R5: fault removal keeps the latch
    railFault = '0;
    expectAt(4, 1'b1, "R5 sticky after removal");
    step(5);

    // R6: undervoltage clears, no timing while low, full restart after
    supplyOk = 1'b0;
    expectAt(1, 1'b0, "R6 clear on undervoltage");
    step(1);
    railFault = 3'b001;
    expectAt(2*TO, 1'b0, "R6 no timing while low");
    step(2*TO);
    supplyOk = 1'b1;
    expectAt(TO-1, 1'b0, "R6 restart from zero");
    expectAt(TO,   1'b1, "R6 trip after restart");
    step(TO);
    releaseLatch();

    // R2: one clean cycle resets the timer
    railFault = 3'b010;
    step(TO-5);
    railFault = '0;
    step(1);
    railFault = 3'b100;
    expectAt(TO-1, 1'b0, "R2 no early trip");
    expectAt(TO,   1'b1, "R2 trip after fresh run");
    step(TO);
    releaseLatch();

    // R1: hand-off between rails keeps the OR continuous
    railFault = 3'b001;
    expectAt(TO-1, 1'b0, "R1 combo before trip");
    expectAt(TO,   1'b1, "R1 combo trip");
    step(7);
    railFault = 3'b011;
    step(5);
    railFault = 3'b110;
    step(4);
    railFault = 3'b100;
    step(TO-16);
    releaseLatch();

    // R7: soft-start masks, then full window afterwards
    softStartActive = 1'b1;
    railFault = 3'b111;
    expectAt(2*TO, 1'b0, "R7 masked during soft-start");
    step(2*TO);
    softStartActive = 1'b0;
    expectAt(TO-1, 1'b0, "R7 full window after ramp");
    expectAt(TO,   1'b1, "R7 trip after ramp");
    step(TO);
    releaseLatch();

    // R7: soft-start mid-count zeroes the timer
    railFault = 3'b010;
    step(TO-3);
    softStartActive = 1'b1;
    step(1);
    softStartActive = 1'b0;
    expectAt(TO-1, 1'b0, "R7 mid-count restart");
    expectAt(TO,   1'b1, "R7 trip after mid-count");
    step(TO);
    releaseLatch();

    // R8: sparse ticks, one every 4 cycles
    railFault = 3'b001;
    expectAt(2*TO, 1'b0, "R8 idle cycles not counted");
    expectAt(4*TO-4, 1'b0, "R8 one before trip");
    expectAt(4*TO-3, 1'b1, "R8 trip on last pulse");
    for (int i = 0; i < TO; i++) begin
      usTick = 1'b1;
      step(1);
      usTick = 1'b0;
      step(3);
    end
    usTick = 1'b1;
    releaseLatch();
    expectAt(0, 1'b0, "R6 released state");
    step(3);

    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule